// File: doc/BRIEF.md
# Channel Zero-Data Detector

This block watches six audio sample streams, each delivered as a signed sample word together with a one-cycle valid strobe. For every channel it keeps a count of how many zero-valued samples have arrived in a row. Once that count reaches the run length (1024 samples by default), the channel's zero flag becomes active. Any nonzero sample clears the count and drops the flag. Cycles without a strobe do not count as samples and leave the run untouched.

The block combines the per-channel flags in two ways. It ANDs each stereo pair (channels 0/1, 2/3 and 4/5) into a pair flag, and it ANDs all six channels into a global flag. A single polarity input selects whether every flag output is driven active high or active low. Downstream logic, such as an automatic mute or a power-saving controller, reads the flags directly.

Top module: `chan_zero_detect`

## Requirements
- R1: While reset is asserted, and after it is released, every run count is zero and every flag output sits at its inactive level. The inactive level is 0 when `pol_low`=0 and 1 when `pol_low`=1.
- R2: A channel flag becomes active on the clock edge that registers the 1024th consecutive zero sample strobed on that channel. After 1023 such samples the flag is still inactive.
- R3: A strobed nonzero sample clears that channel's count and makes its flag inactive at the same edge. A new run then needs a full 1024 zero samples.
- R4: Cycles in which a channel's valid is low change neither its count nor its flag.
- R5: The count saturates at the run length and never wraps. An active flag stays active for any number of further zero samples.
- R6: `pol_low`=0 drives all flags active high and `pol_low`=1 drives them active low. A change of `pol_low` reaches the outputs in the same cycle.
- R7: Pair flag k (bit k of `pair_zero`) is active only when channels 2k and 2k+1 are both active.
- R8: `all_zero` is active only when all six channel flags are active.
- R9: The channels are independent. Samples on one channel never affect another channel's count or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pol_low | input | 1 | Flag polarity: 0 active high, 1 active low |
| smp_valid | input | 6 | Per-channel sample strobe, bit i for channel i |
| smp_data | input | 144 | Six 24-bit samples, channel i in bits [24i+23:24i] |
| zero_flag | output | 6 | Per-channel zero-run flag |
| pair_zero | output | 3 | Stereo-pair flags for channels 2k and 2k+1 |
| all_zero | output | 1 | Global flag: all channels zero |

## Verification
The assertions assume that a strobe lasts one cycle per sample and that data is only meaningful while its strobe is high. They put no constraint on which channels strobe together or on the gaps between strobes. The stimulus drives strobes at random per channel and draws zero data far more often than nonzero data, so runs regularly pass 1024 samples and also break early. Directed sequences cover the 1023/1024 boundary, long idle gaps inside a run, saturation beyond the run length, and flips of `pol_low` while flags are active.

// File: rtl/zd_pkg.sv
package zd_pkg;
  typedef enum logic {
    POL_ACT_HIGH = 1'b0,
    POL_ACT_LOW  = 1'b1
  } zd_pol_e;
endpackage

// File: rtl/zd_run_counter.sv
module zd_run_counter #(
  parameter int SAMPLE_W = 24,
  parameter int RUN_LEN  = 1024
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  output logic                run_hit
);
  localparam int CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] SAT_VAL = CNT_W'(RUN_LEN);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             hit_q, hit_d;
  logic             is_zero;

  assign is_zero = (smp_data == '0);

  always_comb begin
    cnt_d = cnt_q;
    hit_d = hit_q;
    if (smp_valid) begin
      if (is_zero) begin
        if (cnt_q != SAT_VAL) cnt_d = cnt_q + 1'b1;
        hit_d = (cnt_d == SAT_VAL);
      end else begin
        cnt_d = '0;
        hit_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hit_q <= 1'b0;
    end else if (smp_valid) begin
      cnt_q <= cnt_d;
      hit_q <= hit_d;
    end
  end

  assign run_hit = hit_q;

  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= SAT_VAL); // R5
  AST_NONZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !is_zero) |=> (!hit_q && cnt_q == '0)); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> ($stable(cnt_q) && $stable(hit_q))); // R4
  AST_RISE_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit_q) |-> ($past(smp_valid) && $past(is_zero))); // R2
  AST_HIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_q && smp_valid && is_zero) |=> hit_q); // R5
endmodule

// File: rtl/zd_flag_combine.sv
module zd_flag_combine
  import zd_pkg::*;
#(
  parameter int NUM_CH = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CH-1:0]   ch_hit,
  input  zd_pol_e             pol_sel,
  output logic [NUM_CH-1:0]   zero_flag,
  output logic [NUM_CH/2-1:0] pair_zero,
  output logic                all_zero
);
  localparam int NUM_PAIR = NUM_CH / 2;

  logic              inv;
  logic [NUM_PAIR-1:0] pair_hit;
  logic              all_hit;

  assign inv = (pol_sel == POL_ACT_LOW);

  for (genvar k = 0; k < NUM_PAIR; k++) begin : g_pair
    assign pair_hit[k] = ch_hit[2*k] & ch_hit[2*k+1];
  end

  assign all_hit   = &ch_hit;
  assign zero_flag = ch_hit ^ {NUM_CH{inv}};
  assign pair_zero = pair_hit ^ {NUM_PAIR{inv}};
  assign all_zero  = all_hit ^ inv;

  AST_GLOBAL_PAIRS: assert property (@(posedge clk) disable iff (!rst_n)
    (all_zero != inv) |-> (pair_zero == {NUM_PAIR{~inv}})); // R8
  AST_PAIR_MEMBERS: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_zero[0] != inv) |-> (zero_flag[1:0] == {2{~inv}})); // R7
endmodule

// File: rtl/chan_zero_detect.sv
module chan_zero_detect
  import zd_pkg::*;
#(
  parameter int NUM_CH   = 6,
  parameter int SAMPLE_W = 24,
  parameter int RUN_LEN  = 1024
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       pol_low,
  input  logic [NUM_CH-1:0]          smp_valid,
  input  logic [NUM_CH*SAMPLE_W-1:0] smp_data,
  output logic [NUM_CH-1:0]          zero_flag,
  output logic [NUM_CH/2-1:0]        pair_zero,
  output logic                       all_zero
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [NUM_CH-1:0] ch_hit;
  zd_pol_e           pol_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    zd_run_counter #(
      .SAMPLE_W (SAMPLE_W),
      .RUN_LEN  (RUN_LEN)
    ) u_cnt (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .smp_valid (smp_valid[i]),
      .smp_data  (smp_data[i*SAMPLE_W +: SAMPLE_W]),
      .run_hit   (ch_hit[i])
    );
  end

  assign pol_sel = pol_low ? POL_ACT_LOW : POL_ACT_HIGH;

  zd_flag_combine #(
    .NUM_CH (NUM_CH)
  ) u_comb (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .ch_hit    (ch_hit),
    .pol_sel   (pol_sel),
    .zero_flag (zero_flag),
    .pair_zero (pair_zero),
    .all_zero  (all_zero)
  );

  AST_RESET_INACTIVE: assert property (@(posedge clk)
    !rst_int_n |-> (zero_flag == {NUM_CH{pol_low}})); // R1
endmodule

// File: tb/chan_zero_detect_tb.sv
module chan_zero_detect_tb;
  localparam int NCH = 6;
  localparam int SW  = 24;
  localparam int RL  = 1024;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              pol_low;
  logic [NCH-1:0]    smp_valid;
  logic [NCH*SW-1:0] smp_data;
  logic [NCH-1:0]    zero_flag;
  logic [NCH/2-1:0]  pair_zero;
  logic              all_zero;

  int errors = 0;
  int checks = 0;
  int mcnt [NCH];
  bit done = 0;

  always #5 clk = ~clk;

  chan_zero_detect u_dut (
    .clk(clk), .rst_n(rst_n), .pol_low(pol_low), .smp_valid(smp_valid),
    .smp_data(smp_data), .zero_flag(zero_flag), .pair_zero(pair_zero),
    .all_zero(all_zero)
  );

  function automatic logic [NCH-1:0] exp_flags();
    logic [NCH-1:0] f;
    for (int i = 0; i < NCH; i++) f[i] = (mcnt[i] >= RL) ^ pol_low;
    return f;
  endfunction

  function automatic logic [NCH/2-1:0] exp_pairs();
    logic [NCH/2-1:0] p;
    for (int k = 0; k < NCH/2; k++)
      p[k] = ((mcnt[2*k] >= RL) && (mcnt[2*k+1] >= RL)) ^ pol_low;
    return p;
  endfunction

  function automatic logic exp_all();
    logic a = 1'b1;
    for (int i = 0; i < NCH; i++) a = a && (mcnt[i] >= RL);
    return a ^ pol_low;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmp_model(string tag);
    check({tag, " zero_flag"}, 32'(zero_flag), 32'(exp_flags()));
    check({tag, " pair_zero"}, 32'(pair_zero), 32'(exp_pairs()));
    check({tag, " all_zero"},  32'(all_zero),  32'(exp_all()));
  endtask

  // drive one cycle; nz marks channels carrying a nonzero sample
  task automatic step(logic [NCH-1:0] v, logic [NCH-1:0] nz);
    @(negedge clk);
    smp_valid = v;
    for (int i = 0; i < NCH; i++)
      smp_data[i*SW +: SW] = nz[i] ? SW'(($urandom % 24'hFFFFFE) + 1) : '0;
    @(posedge clk);
    #1;
    for (int i = 0; i < NCH; i++)
      if (v[i]) mcnt[i] = nz[i] ? 0 : ((mcnt[i] < RL) ? mcnt[i] + 1 : RL);
  endtask

  task automatic run(logic [NCH-1:0] v, logic [NCH-1:0] nz, int n);
    for (int j = 0; j < n; j++) step(v, nz);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    smp_valid = '0;
    smp_data = '0;
    for (int i = 0; i < NCH; i++) mcnt[i] = 0;
    #1;
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    #(1500000 * 1ns);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0A11));
    rst_n = 1'b0;
    pol_low = 1'b0;
    smp_valid = '0;
    smp_data = '0;
    for (int i = 0; i < NCH; i++) mcnt[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset active-high", 32'({zero_flag, pair_zero, all_zero}), 32'h0);
    pol_low = 1'b1;
    #1;
    check("R6 R1 reset active-low", 32'({zero_flag, pair_zero, all_zero}), 32'h3FF);
    pol_low = 1'b0;
    release_reset();
    cmp_model("R1 after release");

    // R2 boundary
    run(6'b000001, 6'b0, RL - 1);
    check("R2 1023 zeros", 32'(zero_flag[0]), 32'h0);
    step(6'b000001, 6'b0);
    check("R2 1024 zeros", 32'(zero_flag[0]), 32'h1);
    check("R9 other channels", 32'(zero_flag[5:1]), 32'h0);

    // R4 idle cycles
    run(6'b000000, 6'b0, 50);
    check("R4 idle keeps flag", 32'(zero_flag[0]), 32'h1);
    run(6'b000010, 6'b0, 500);
    run(6'b000000, 6'b0, 100);
    run(6'b000010, 6'b0, RL - 501);
    check("R4 gap inside run 1023", 32'(zero_flag[1]), 32'h0);
    step(6'b000010, 6'b0);
    check("R4 gap inside run 1024", 32'(zero_flag[1]), 32'h1);
    check("R7 pair0 both", 32'(pair_zero), 32'h1);

    // R5 saturation
    run(6'b000001, 6'b0, 1500);
    check("R5 saturated", 32'(zero_flag[0]), 32'h1);

    // R3 nonzero clears
    step(6'b000001, 6'b000001);
    check("R3 nonzero clears", 32'(zero_flag[0]), 32'h0);
    check("R7 pair0 drops", 32'(pair_zero[0]), 32'h0);
    check("R9 ch1 untouched", 32'(zero_flag[1]), 32'h1);
    run(6'b000001, 6'b0, RL - 1);
    check("R3 new run 1023", 32'(zero_flag[0]), 32'h0);
    step(6'b000001, 6'b0);
    check("R3 new run 1024", 32'(zero_flag[0]), 32'h1);

    // R7 R8 global
    run(6'b111111, 6'b0, RL);
    check("R8 all active", 32'(all_zero), 32'h1);
    check("R7 all pairs", 32'(pair_zero), 32'h7);
    step(6'b001000, 6'b001000);
    check("R8 one channel breaks global", 32'(all_zero), 32'h0);
    check("R7 pair1 drops", 32'(pair_zero), 32'h5);
    pol_low = 1'b1;
    #1;
    check("R6 flags invert", 32'(zero_flag), 32'h08);
    check("R6 pairs invert", 32'(pair_zero), 32'h2);
    check("R6 global invert", 32'(all_zero), 32'h1);
    pol_low = 1'b0;
    #1;
    cmp_model("R6 restore");

    // random phase
    for (int c = 0; c < 20000; c++) begin
      logic [NCH-1:0] v, nz;
      for (int i = 0; i < NCH; i++) begin
        v[i]  = ($urandom % 4) != 0;
        nz[i] = ($urandom % 1800) == 0;
      end
      if (($urandom % 3000) == 0) pol_low = ~pol_low;
      step(v, nz);
      cmp_model("R2 R3 R4 R5 R7 R8 R9 random");
    end

    // R1 asynchronous reset mid-run
    pol_low = 1'b0;
    run(6'b111111, 6'b0, RL);
    cmp_model("R8 before reset");
    do_reset();
    check("R1 async reset clears", 32'({zero_flag, pair_zero, all_zero}), 32'h0);
    release_reset();
    run(6'b111111, 6'b0, 10);
    cmp_model("R1 counts restart");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule